// File: doc/BRIEF.md
# Four-Bit Accumulator Processor Core

A compact processor that executes one instruction per enabled clock cycle on 4-bit data. The program counter addresses an external program store. Each fetched byte carries an opcode nibble and a constant nibble. The core contains an accumulator, an 8-bit program counter, a data-address register and a 16-nibble data store. The top data address is not storage: it is mapped onto an external input port for reads and an external output port for writes.

A store does not write at once. It latches the target address, and the accumulator is written during the next instruction. A read that lands in that cycle is served from the accumulator, so a store followed by a memory read still sees the stored value. The carry of an ADD, and the fact that an ADD ran, are held for one cycle. The conditional jump uses them only when it directly follows an ADD. In every other position it behaves as a plain jump.

Top module: `cpu4_core`

## Requirements
- R1: While `rst_ni` is low, `pc_o`, `acc_o` and `out_port_o` are zero, and no data write takes place during or straight after reset.
- R2: With `CONST_HI=1`, a program byte holds the constant in bits 7:4 and the opcode nibble in bits 3:0. Opcode bits 3:1 select the operation: 0 LOAD, 1 ADD, 2 NAND, 3 XOR, 4 STORE, 5 READ, 6 JUMP, 7 JNC. Bit 0 set picks the data at the current data address as operand; bit 0 clear picks the constant.
- R3: LOAD, NAND (`~(acc & b)`) and XOR (`acc ^ b`) update the accumulator at the end of the same cycle.
- R4: ADD sets the accumulator to `(acc + b) mod 16` and captures the carry out.
- R5: The program counter advances by one on each enabled cycle that does not take a jump. With `en_i` low, all state holds.
- R6: A taken jump loads the program counter with the current page nibble (`pc[7:4]`) above the operand nibble.
- R7: JNC directly after an ADD jumps only if that ADD produced no carry. In any other position it always jumps.
- R8: STORE loads the data address from its operand, and the accumulator is written there during the next cycle. Two STOREs in a row both write.
- R9: A memory operand read in the cycle right after a STORE returns the accumulator value that was stored.
- R10: Data address 15 reads `in_port_i` and writes `out_port_o`. `out_port_o` changes only on such a write.
- R11: READ loads the data address from its operand. Memory-operand instructions then use the data held at that address.
- R12: `acc_o` always shows the accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Clock enable; low freezes the core |
| pc_o | output | 8 | Program address |
| prog_i | input | 8 | Program byte at `pc_o` |
| in_port_i | input | 4 | Input port, read at data address 15 |
| out_port_o | output | 4 | Output port, written at data address 15 |
| acc_o | output | 4 | Accumulator monitor |

## Verification
A wrong program counter or a wrong carry/ADD history shows on `pc_o` one cycle after the instruction that used it, because every jump decision resolves in a single edge. Wrong data storage or a missing store bypass stays hidden until a later memory-operand instruction runs. It then appears on `acc_o` one edge after that read. A misrouted I/O write shows on `out_port_o` on the edge that ends the instruction following the STORE.

// File: rtl/cpu4_pkg.sv
package cpu4_pkg;
  typedef enum logic [2:0] {
    OP_LOAD  = 3'd0,
    OP_ADD   = 3'd1,
    OP_NAND  = 3'd2,
    OP_XOR   = 3'd3,
    OP_STORE = 3'd4,
    OP_READ  = 3'd5,
    OP_JUMP  = 3'd6,
    OP_JNC   = 3'd7
  } op_e;

  typedef enum logic [1:0] {
    FN_ADD  = 2'd0,
    FN_LOAD = 2'd1,
    FN_NAND = 2'd2,
    FN_XOR  = 2'd3
  } alu_fn_e;

  typedef struct packed {
    logic    acc_we;
    alu_fn_e fn;
    logic    use_mem;
    logic    store;
    logic    read;
    logic    jump;
    logic    jnc;
    logic    is_add;
  } ctrl_t;
endpackage

// File: rtl/cpu4_decode.sv
module cpu4_decode
  import cpu4_pkg::*;
(
  input  logic [3:0] inst_i,
  output ctrl_t      ctrl_o
);
  op_e op;
  assign op = op_e'(inst_i[3:1]);

  always_comb begin
    ctrl_o         = '0;
    ctrl_o.use_mem = inst_i[0];
    ctrl_o.fn      = FN_LOAD;
    unique case (op)
      OP_LOAD:  begin ctrl_o.acc_we = 1'b1; ctrl_o.fn = FN_LOAD; end
      OP_ADD:   begin ctrl_o.acc_we = 1'b1; ctrl_o.fn = FN_ADD; ctrl_o.is_add = 1'b1; end
      OP_NAND:  begin ctrl_o.acc_we = 1'b1; ctrl_o.fn = FN_NAND; end
      OP_XOR:   begin ctrl_o.acc_we = 1'b1; ctrl_o.fn = FN_XOR; end
      OP_STORE: ctrl_o.store = 1'b1;
      OP_READ:  ctrl_o.read  = 1'b1;
      OP_JUMP:  ctrl_o.jump  = 1'b1;
      OP_JNC:   ctrl_o.jnc   = 1'b1;
      default:  ;
    endcase
  end
endmodule

// File: rtl/cpu4_alu.sv
module cpu4_alu
  import cpu4_pkg::*;
#(
  parameter int DW = 4
) (
  input  alu_fn_e       fn_i,
  input  logic [DW-1:0] a_i,
  input  logic [DW-1:0] b_i,
  output logic [DW-1:0] y_o,
  output logic          carry_o
);
  logic [DW:0] sum;
  assign sum = {1'b0, a_i} + {1'b0, b_i};

  always_comb begin
    carry_o = 1'b0;
    unique case (fn_i)
      FN_ADD:  begin y_o = sum[DW-1:0]; carry_o = sum[DW]; end
      FN_LOAD: y_o = b_i;
      FN_NAND: y_o = ~(a_i & b_i);
      FN_XOR:  y_o = a_i ^ b_i;
      default: y_o = b_i;
    endcase
  end
endmodule

// File: rtl/cpu4_datamem.sv
module cpu4_datamem #(
  parameter int DW = 4
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          en_i,
  input  logic          store_i,
  input  logic          read_i,
  input  logic [DW-1:0] addr_i,
  input  logic [DW-1:0] acc_i,
  input  logic [DW-1:0] in_port_i,
  output logic [DW-1:0] rd_data_o,
  output logic [DW-1:0] out_port_o
);
  localparam int DEPTH = 2 ** DW;
  localparam logic [DW-1:0] IO_ADDR = DW'(DEPTH - 1);

  logic [DW-1:0] mem_q [DEPTH];
  logic [DW-1:0] mar_q;
  logic          wr_pend_q;
  logic [DW-1:0] out_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mar_q     <= '0;
      wr_pend_q <= 1'b0;
    end else if (en_i) begin
      wr_pend_q <= store_i;
      if (store_i || read_i) mar_q <= addr_i;
    end
  end

  // delayed write: uses address latched by the preceding STORE
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
      out_q <= '0;
    end else if (en_i && wr_pend_q) begin
      if (mar_q == IO_ADDR) out_q <= acc_i;
      else                  mem_q[mar_q] <= acc_i;
    end
  end

  // bypass covers the read in the write cycle
  always_comb begin
    if (wr_pend_q)              rd_data_o = acc_i;
    else if (mar_q == IO_ADDR)  rd_data_o = in_port_i;
    else                        rd_data_o = mem_q[mar_q];
  end

  assign out_port_o = out_q;

  AST_STORE_PENDS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && store_i) |=> wr_pend_q); // R8
  AST_BYPASS_ACC: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_pend_q |-> (rd_data_o == acc_i)); // R9
  AST_OUT_ONLY_IO_WR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(en_i && wr_pend_q && mar_q == IO_ADDR) |=> $stable(out_q)); // R10
  AST_IO_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_pend_q && mar_q == IO_ADDR) |-> (rd_data_o == in_port_i)); // R10
endmodule

// File: rtl/cpu4_flow.sv
module cpu4_flow #(
  parameter int DW  = 4,
  parameter int PCW = 8
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           en_i,
  input  logic           jump_i,
  input  logic           jnc_i,
  input  logic           is_add_i,
  input  logic           carry_i,
  input  logic [DW-1:0]  target_i,
  output logic [PCW-1:0] pc_o
);
  logic [PCW-1:0] pc_q;
  logic           add_q, carry_q;
  logic           take;

  assign take = jump_i | (jnc_i & ~(add_q & carry_q));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pc_q    <= '0;
      add_q   <= 1'b0;
      carry_q <= 1'b0;
    end else if (en_i) begin
      add_q   <= is_add_i;
      carry_q <= is_add_i & carry_i;
      if (take) pc_q <= {pc_q[PCW-1:DW], target_i};
      else      pc_q <= pc_q + PCW'(1);
    end
  end

  assign pc_o = pc_q;

  AST_PC_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !jump_i && !jnc_i) |=> (pc_q == $past(pc_q) + PCW'(1))); // R5
  AST_PC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(pc_q)); // R5
  AST_JUMP_PAGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && jump_i) |=> (pc_q == {$past(pc_q[PCW-1:DW]), $past(target_i)})); // R6
  AST_JNC_UNCOND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && jnc_i && !add_q) |=> (pc_q[DW-1:0] == $past(target_i))); // R7
endmodule

// File: rtl/cpu4_core.sv
module cpu4_core
  import cpu4_pkg::*;
#(
  parameter int DW       = 4,
  parameter int PCW      = 8,
  parameter bit CONST_HI = 1'b1
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           en_i,
  output logic [PCW-1:0] pc_o,
  input  logic [2*DW-1:0] prog_i,
  input  logic [DW-1:0]  in_port_i,
  output logic [DW-1:0]  out_port_o,
  output logic [DW-1:0]  acc_o
);
  logic [DW-1:0] inst, konst, operand, mem_rd, alu_y;
  logic [DW-1:0] acc_q;
  logic          alu_c;
  ctrl_t         ctrl;

  generate
    if (CONST_HI) begin : g_const_hi
      assign konst = prog_i[2*DW-1:DW];
      assign inst  = prog_i[DW-1:0];
    end else begin : g_const_lo
      assign konst = prog_i[DW-1:0];
      assign inst  = prog_i[2*DW-1:DW];
    end
  endgenerate

  cpu4_decode u_dec (.inst_i(inst[3:0]), .ctrl_o(ctrl));

  assign operand = ctrl.use_mem ? mem_rd : konst;

  cpu4_alu #(.DW(DW)) u_alu (
    .fn_i(ctrl.fn), .a_i(acc_q), .b_i(operand), .y_o(alu_y), .carry_o(alu_c)
  );

  cpu4_datamem #(.DW(DW)) u_mem (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i),
    .store_i(ctrl.store), .read_i(ctrl.read), .addr_i(operand),
    .acc_i(acc_q), .in_port_i(in_port_i),
    .rd_data_o(mem_rd), .out_port_o(out_port_o)
  );

  cpu4_flow #(.DW(DW), .PCW(PCW)) u_flow (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i),
    .jump_i(ctrl.jump), .jnc_i(ctrl.jnc), .is_add_i(ctrl.is_add),
    .carry_i(alu_c), .target_i(operand), .pc_o(pc_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                 acc_q <= '0;
    else if (en_i && ctrl.acc_we) acc_q <= alu_y;
  end

  assign acc_o = acc_q;

  AST_ACC_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i || !ctrl.acc_we) |=> $stable(acc_o)); // R12
  AST_ACC_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && ctrl.acc_we && ctrl.fn == FN_LOAD) |=> (acc_o == $past(operand))); // R3
endmodule

// File: tb/cpu4_core_test.sv
module cpu4_core_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       en = 1'b1;
  logic [7:0] pc;
  logic [7:0] prog;
  logic [3:0] in_port = 4'h0;
  logic [3:0] out_port, acc;
  logic [7:0] rom [256];
  int checks = 0, fails = 0;

  always #10 clk = ~clk;

  assign prog = rom[pc];

  cpu4_core uut (
    .clk_i(clk), .rst_ni(rst_n), .en_i(en), .pc_o(pc), .prog_i(prog),
    .in_port_i(in_port), .out_port_o(out_port), .acc_o(acc)
  );

  localparam logic [2:0] LD = 3'd0, AD = 3'd1, NA = 3'd2, XO = 3'd3,
                         ST = 3'd4, RD = 3'd5, JP = 3'd6, JC = 3'd7;

  function automatic logic [7:0] mk(logic [2:0] op, logic m, logic [3:0] k);
    return {k, op, m};
  endfunction

  task automatic check(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic clear_rom();
    for (int i = 0; i < 256; i++) rom[i] = 8'h00;
  endtask

  task automatic restart();
    @(negedge clk);
    rst_n = 1'b0;
    en = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    clear_rom();
    rom[0] = mk(ST, 1'b0, 4'hF);
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 pc", pc, 8'h00);
    check("R1 acc", {4'h0, acc}, 8'h00);
    check("R1 out", {4'h0, out_port}, 8'h00);
    rst_n = 1'b1;
    step(1);
    // STORE executed but no write during reset or right after
    check("R1 no write", {4'h0, out_port}, 8'h00);
  endtask

  task automatic t_alu();
    clear_rom();
    rom[0] = mk(LD, 1'b0, 4'h5);
    rom[1] = mk(AD, 1'b0, 4'h3);
    rom[2] = mk(NA, 1'b0, 4'hC);
    rom[3] = mk(XO, 1'b0, 4'hF);
    restart();
    step(1); check("R3 R2 load", {4'h0, acc}, 8'h05);
    step(1); check("R4 add", {4'h0, acc}, 8'h08);
    step(1); check("R3 nand", {4'h0, acc}, 8'h07);
    step(1); check("R3 xor", {4'h0, acc}, 8'h08);
    check("R5 pc", pc, 8'h04);
    en = 1'b0;
    step(3);
    check("R5 hold pc", pc, 8'h04);
    check("R12 hold acc", {4'h0, acc}, 8'h08);
    en = 1'b1;
  endtask

  task automatic t_jumps();
    clear_rom();
    rom[0]  = mk(LD, 1'b0, 4'hE);
    rom[1]  = mk(AD, 1'b0, 4'h3);
    rom[2]  = mk(JC, 1'b0, 4'h8);
    rom[3]  = mk(AD, 1'b0, 4'h1);
    rom[4]  = mk(JC, 1'b0, 4'h9);
    rom[9]  = mk(LD, 1'b0, 4'h4);
    rom[10] = mk(JC, 1'b0, 4'hC);
    rom[12] = mk(JP, 1'b0, 4'h2);
    restart();
    step(3); check("R7 carry blocks jnc", pc, 8'h03);
    check("R4 wrap", {4'h0, acc}, 8'h01);
    step(2); check("R7 no carry jnc", pc, 8'h09);
    step(2); check("R7 jnc after load", pc, 8'h0C);
    step(1); check("R6 jump", pc, 8'h02);
    step(1); check("R7 jnc after jump", pc, 8'h08);
  endtask

  task automatic t_page();
    clear_rom();
    rom[8'h11] = mk(JP, 1'b0, 4'h3);
    restart();
    step(17); check("R5 count", pc, 8'h11);
    step(1);  check("R6 page kept", pc, 8'h13);
  endtask

  task automatic t_store();
    clear_rom();
    rom[0]  = mk(LD, 1'b0, 4'h6);
    rom[1]  = mk(ST, 1'b0, 4'h2);
    rom[2]  = mk(XO, 1'b1, 4'h0);
    rom[3]  = mk(LD, 1'b0, 4'h9);
    rom[4]  = mk(ST, 1'b0, 4'h3);
    rom[5]  = mk(ST, 1'b0, 4'h4);
    rom[6]  = mk(LD, 1'b0, 4'h0);
    rom[7]  = mk(RD, 1'b0, 4'h3);
    rom[8]  = mk(LD, 1'b1, 4'h0);
    rom[9]  = mk(RD, 1'b0, 4'h4);
    rom[10] = mk(AD, 1'b1, 4'h0);
    rom[11] = mk(RD, 1'b0, 4'h2);
    rom[12] = mk(LD, 1'b1, 4'h0);
    restart();
    step(3);  check("R9 bypass", {4'h0, acc}, 8'h00);
    step(6);  check("R8 R11 first of pair", {4'h0, acc}, 8'h09);
    step(2);  check("R8 second of pair", {4'h0, acc}, 8'h02);
    step(2);  check("R8 delayed write", {4'h0, acc}, 8'h06);
  endtask

  task automatic t_io();
    clear_rom();
    rom[0] = mk(RD, 1'b0, 4'hF);
    rom[1] = mk(LD, 1'b1, 4'h0);
    rom[2] = mk(XO, 1'b0, 4'h5);
    rom[3] = mk(ST, 1'b0, 4'hF);
    rom[4] = mk(LD, 1'b0, 4'h1);
    rom[5] = mk(LD, 1'b1, 4'h0);
    in_port = 4'hA;
    restart();
    step(2); check("R10 in read", {4'h0, acc}, 8'h0A);
    step(2); check("R10 out not yet", {4'h0, out_port}, 8'h00);
    step(1); check("R10 out write", {4'h0, out_port}, 8'h0F);
    check("R12 monitor", {4'h0, acc}, 8'h01);
    in_port = 4'h3;
    step(1); check("R10 in live", {4'h0, acc}, 8'h03);
    check("R10 out held", {4'h0, out_port}, 8'h0F);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    clear_rom();
    t_reset();
    t_alu();
    t_jumps();
    t_page();
    t_store();
    t_io();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule